// File: doc/BRIEF.md
# Decode-Stage Read-After-Write Stall Detector

This block decides, for a five-stage in-order integer pipeline without any bypass network, whether the instruction sitting in decode must wait. It compares the decode instruction's two source register indices against the destination of every older instruction that is still in flight. Those older instructions sit in three places: the decode-to-execute register, the execute-to-memory register and the memory-to-writeback register. If a source would read a value that has not yet been written back, the block freezes fetch and decode. It also turns the instruction entering execute into a bubble.

The block is purely combinational. Its inputs are taken from the pipeline registers in the same cycle the decision is used, so the hazard is resolved before the instruction issues.

For the youngest producer, the block selects the destination itself. It chooses between that stage's two register fields using the stage's destination-select bit. The two older stages already carry a resolved write index.

Each source comparison is gated by a flag from decode saying whether that operand is really read. Register 0 is treated as a constant that never creates a dependency.

Top module: `raw_stall_unit`

## Requirements
- R1: When the decode-to-execute write enable is 1 and its selected destination equals a used decode source, the stall is raised.
- R2: The destination-select bit chooses the destination. A value of 0 picks the `ex_rt_idx` field and a value of 1 picks the `ex_rd_idx` field. The unselected field never causes a stall.
- R3: When the execute-to-memory write enable is 1 and `mem_wr_idx` equals a used decode source, the stall is raised.
- R4: When the memory-to-writeback write enable is 1 and `wb_wr_idx` equals a used decode source, the stall is raised.
- R5: A stage whose write enable is 0 never contributes to the stall, whatever its register fields hold. This covers stores and branches in the execute-to-memory stage.
- R6: Register index 0 never produces a match, either as a source or as a destination.
- R7: A source whose used flag is 0 never produces a match.
- R8: While stalled, `pc_we` is 0, `ifid_we` is 0 and `idex_bubble` is 1. Otherwise they are 1, 1 and 0.
- R9: The stall is the OR of all stage checks. It follows the same-cycle inputs with no clock delay, and it holds for arbitrary combinations of the stage checks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs_idx | input | 5 | First source register index of the decode instruction |
| dec_rt_idx | input | 5 | Second source register index of the decode instruction |
| dec_rs_used | input | 1 | First source is actually read |
| dec_rt_used | input | 1 | Second source is actually read |
| ex_wr_en | input | 1 | Decode-to-execute stage writes a register |
| ex_dst_sel | input | 1 | Destination select: 0 = rt field, 1 = rd field |
| ex_rt_idx | input | 5 | rt field held in the decode-to-execute register |
| ex_rd_idx | input | 5 | rd field held in the decode-to-execute register |
| mem_wr_en | input | 1 | Execute-to-memory stage writes a register |
| mem_wr_idx | input | 5 | Resolved write index in execute-to-memory |
| wb_wr_en | input | 1 | Memory-to-writeback stage writes a register |
| wb_wr_idx | input | 5 | Resolved write index in memory-to-writeback |
| pc_we | output | 1 | Program counter update enable |
| ifid_we | output | 1 | Fetch-to-decode register write enable |
| idex_bubble | output | 1 | Clear control fields entering decode-to-execute |

## Verification
The bench places the wanted destination in the unselected rt or rd field, so a design that ignored the select bit would stall when it should not, or miss a real hazard. It drives register 0 on both sides of a comparison with enables set, which catches a design that stalls forever on instructions writing the zero register. It sets used flags to 0 on matching fields and write enables to 0 on matching stages, which exposes immediate-form operands or stores falsely freezing the pipe. Single-stage matches for each of the three stages, plus a long random sweep, catch a dropped term in the OR or inverted output polarity.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
   localparam int NUM_PRODUCERS = 3;
   typedef enum logic [1:0] {
      PROD_EX  = 2'd0,
      PROD_MEM = 2'd1,
      PROD_WB  = 2'd2
   } hzd_prod_e;
endpackage

// File: rtl/hzd_dst_pick.sv
module hzd_dst_pick #(
   parameter int AW = 5
) (
   input  logic          use_rd,
   input  logic [AW-1:0] rt_field,
   input  logic [AW-1:0] rd_field,
   output logic [AW-1:0] dst
);
   if (AW < 1) begin : g_bad_aw
      $error("hzd_dst_pick: AW must be positive");
   end

   assign dst = use_rd ? rd_field : rt_field;
endmodule

// File: rtl/hzd_cmp.sv
module hzd_cmp #(
   parameter int AW          = 5,
   parameter bit ZERO_FILTER = 1'b1
) (
   input  logic          wr_en,
   input  logic [AW-1:0] dst,
   input  logic [AW-1:0] src_a,
   input  logic [AW-1:0] src_b,
   input  logic          src_a_used,
   input  logic          src_b_used,
   output logic          hit
);
   logic eq_a, eq_b, dst_live;

   assign eq_a = (dst == src_a) && src_a_used;
   assign eq_b = (dst == src_b) && src_b_used;

   if (ZERO_FILTER) begin : g_zero_const
      assign dst_live = wr_en && (dst != '0);
   end else begin : g_zero_plain
      assign dst_live = wr_en;
   end

   assign hit = dst_live && (eq_a || eq_b);

   always_comb begin
      if (hit) begin
         // R5
         hit_needs_wr_chk: assert (wr_en) else $error("hit with write disabled");
         // R7
         hit_needs_used_chk: assert (src_a_used || src_b_used) else $error("hit with no used source");
         // R6
         hit_zero_chk: assert (!ZERO_FILTER || dst != '0) else $error("hit on register zero");
      end
   end
endmodule

// File: rtl/hzd_stall_ctl.sv
module hzd_stall_ctl #(
   parameter int N = 3
) (
   input  logic [N-1:0] hits,
   output logic         pc_we,
   output logic         ifid_we,
   output logic         idex_bubble
);
   if (N < 1) begin : g_bad_n
      $error("hzd_stall_ctl: N must be positive");
   end

   logic stall;
   assign stall       = |hits;
   assign pc_we       = ~stall;
   assign ifid_we     = ~stall;
   assign idex_bubble = stall;
endmodule

// File: rtl/raw_stall_unit.sv
module raw_stall_unit #(
   parameter int AW          = 5,
   parameter bit ZERO_FILTER = 1'b1
) (
   input  logic [AW-1:0] dec_rs_idx,
   input  logic [AW-1:0] dec_rt_idx,
   input  logic          dec_rs_used,
   input  logic          dec_rt_used,
   input  logic          ex_wr_en,
   input  logic          ex_dst_sel,
   input  logic [AW-1:0] ex_rt_idx,
   input  logic [AW-1:0] ex_rd_idx,
   input  logic          mem_wr_en,
   input  logic [AW-1:0] mem_wr_idx,
   input  logic          wb_wr_en,
   input  logic [AW-1:0] wb_wr_idx,
   output logic          pc_we,
   output logic          ifid_we,
   output logic          idex_bubble
);
   import hzd_pkg::*;

   localparam int NP = NUM_PRODUCERS;

   if (AW < 1 || AW > 8) begin : g_bad_aw
      $error("raw_stall_unit: AW out of range");
   end

   logic [AW-1:0] ex_dst;
   logic [AW-1:0] prod_dst [NP];
   logic [NP-1:0] prod_en;
   logic [NP-1:0] prod_hit;

   hzd_dst_pick #(.AW(AW)) u_pick (
      .use_rd   (ex_dst_sel),
      .rt_field (ex_rt_idx),
      .rd_field (ex_rd_idx),
      .dst      (ex_dst)
   );

   assign prod_dst[PROD_EX]  = ex_dst;
   assign prod_dst[PROD_MEM] = mem_wr_idx;
   assign prod_dst[PROD_WB]  = wb_wr_idx;
   assign prod_en[PROD_EX]   = ex_wr_en;
   assign prod_en[PROD_MEM]  = mem_wr_en;
   assign prod_en[PROD_WB]   = wb_wr_en;

   for (genvar g = 0; g < NP; g++) begin : g_prod
      hzd_cmp #(.AW(AW), .ZERO_FILTER(ZERO_FILTER)) u_cmp (
         .wr_en      (prod_en[g]),
         .dst        (prod_dst[g]),
         .src_a      (dec_rs_idx),
         .src_b      (dec_rt_idx),
         .src_a_used (dec_rs_used),
         .src_b_used (dec_rt_used),
         .hit        (prod_hit[g])
      );
   end

   hzd_stall_ctl #(.N(NP)) u_ctl (
      .hits        (prod_hit),
      .pc_we       (pc_we),
      .ifid_we     (ifid_we),
      .idex_bubble (idex_bubble)
   );

   always_comb begin
      // R8
      hold_pair_chk: assert (pc_we == ifid_we) else $error("pc and fetch enables differ");
      // R8
      bubble_pol_chk: assert (idex_bubble != pc_we) else $error("bubble not opposite of pc enable");
      // R5
      if (idex_bubble) begin
         stall_src_chk: assert (ex_wr_en || mem_wr_en || wb_wr_en) else $error("stall with no writer");
      end
      // R7
      if (!dec_rs_used && !dec_rt_used) begin
         no_src_chk: assert (!idex_bubble) else $error("stall with no sources read");
      end
   end
endmodule

// File: tb/raw_stall_unit_tb.sv
`timescale 1ns/1ps
module raw_stall_unit_tb_top;
   localparam int AW = 5;

   typedef struct {
      string tag;
      bit    stall;
   } exp_t;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [AW-1:0] rs = '0, rt = '0, exrt = '0, exrd = '0, mi = '0, wi = '0;
   logic rsu = 1'b0, rtu = 1'b0, exen = 1'b0, exsel = 1'b0, men = 1'b0, wen = 1'b0;
   logic pc_we, ifid_we, idex_bubble;

   exp_t q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   raw_stall_unit #(.AW(AW)) dut_i (
      .dec_rs_idx(rs), .dec_rt_idx(rt), .dec_rs_used(rsu), .dec_rt_used(rtu),
      .ex_wr_en(exen), .ex_dst_sel(exsel), .ex_rt_idx(exrt), .ex_rd_idx(exrd),
      .mem_wr_en(men), .mem_wr_idx(mi), .wb_wr_en(wen), .wb_wr_idx(wi),
      .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble)
   );

   function automatic bit dep(bit en, logic [AW-1:0] d, logic [AW-1:0] a, logic [AW-1:0] b,
                              bit ua, bit ub);
      if (!en || d == 0) return 1'b0;
      return (ua && a == d) || (ub && b == d);
   endfunction

   task automatic drive(string tag,
                        logic [AW-1:0] s1, logic [AW-1:0] s2, bit u1, bit u2,
                        bit e_en, bit e_sel, logic [AW-1:0] e_rt, logic [AW-1:0] e_rd,
                        bit m_en, logic [AW-1:0] m_i, bit w_en, logic [AW-1:0] w_i);
      exp_t it;
      @(posedge clk);
      rs = s1; rt = s2; rsu = u1; rtu = u2;
      exen = e_en; exsel = e_sel; exrt = e_rt; exrd = e_rd;
      men = m_en; mi = m_i; wen = w_en; wi = w_i;
      it.tag   = tag;
      it.stall = dep(e_en, e_sel ? e_rd : e_rt, s1, s2, u1, u2) ||
                 dep(m_en, m_i, s1, s2, u1, u2) ||
                 dep(w_en, w_i, s1, s2, u1, u2);
      q.push_back(it);
   endtask

   initial begin : monitor
      exp_t it;
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            it = q.pop_front();
            checks++;
            if (pc_we !== !it.stall || ifid_we !== !it.stall || idex_bubble !== it.stall) begin
               errors++;
               $display("FAIL %s: pc_we=%b ifid_we=%b bubble=%b expected stall=%b",
                        it.tag, pc_we, ifid_we, idex_bubble, it.stall);
            end
         end
      end
   end

   initial begin : watchdog
      #(5.0 * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : driver
      // idle state: no writers, expect run (R8)
      drive("R8_idle", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      // R1 youngest producer with rt destination
      drive("R1_ex_rt", 5'd3, 5'd9, 1, 1, 1, 0, 5'd3, 5'd20, 0, 0, 0, 0);
      // R1 youngest producer with rd destination against rt source
      drive("R1_ex_rd", 5'd4, 5'd7, 1, 1, 1, 1, 5'd1, 5'd7, 0, 0, 0, 0);
      // R2 unselected rd field matches, select picks rt
      drive("R2_unsel_rd", 5'd6, 5'd8, 1, 1, 1, 0, 5'd2, 5'd6, 0, 0, 0, 0);
      // R2 unselected rt field matches, select picks rd
      drive("R2_unsel_rt", 5'd6, 5'd8, 1, 1, 1, 1, 5'd8, 5'd2, 0, 0, 0, 0);
      // R3 middle stage match on rs
      drive("R3_mem_rs", 5'd11, 5'd12, 1, 1, 0, 0, 0, 0, 1, 5'd11, 0, 0);
      // R4 oldest stage match on rt
      drive("R4_wb_rt", 5'd13, 5'd14, 1, 1, 0, 0, 0, 0, 0, 0, 1, 5'd14);
      // R5 all stages match but write disabled (store-like)
      drive("R5_no_wr", 5'd15, 5'd15, 1, 1, 0, 0, 5'd15, 5'd15, 0, 5'd15, 0, 5'd15);
      // R6 zero register everywhere with writes enabled
      drive("R6_zero", 5'd0, 5'd0, 1, 1, 1, 1, 5'd0, 5'd0, 1, 5'd0, 1, 5'd0);
      // R7 matching source not used
      drive("R7_rt_unused", 5'd1, 5'd17, 1, 0, 0, 0, 0, 0, 1, 5'd17, 0, 0);
      drive("R7_rs_unused", 5'd18, 5'd2, 0, 1, 0, 0, 0, 0, 0, 0, 1, 5'd18);
      // R8 stall polarity from a simple hit, then release
      drive("R8_stall", 5'd21, 5'd22, 1, 1, 1, 1, 5'd0, 5'd22, 0, 0, 0, 0);
      drive("R8_release", 5'd21, 5'd22, 1, 1, 1, 1, 5'd0, 5'd23, 0, 0, 0, 0);
      // R9 random sweep of combined stage terms
      for (int i = 0; i < 400; i++) begin
         drive("R9_rand", AW'($urandom_range(0, 7)), AW'($urandom_range(0, 7)),
               1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               AW'($urandom_range(0, 7)), AW'($urandom_range(0, 7)),
               1'($urandom), AW'($urandom_range(0, 7)),
               1'($urandom), AW'($urandom_range(0, 7)));
      end
      while (q.size() > 0) @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule